// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Bank

This block is a small memory-mapped timer with two or three channels, set by a parameter. Each channel holds a 32-bit counter that counts down once per prescaled tick, where the tick is the peripheral clock divided by 4, 16, 64, 256 or 1024. When the counter passes below zero, it reloads from the channel's constant register. It also sets a sticky underflow flag and, if the channel's interrupt enable is set, drives that channel's interrupt line high.

All channels share one run-control byte, and each channel has a bit in it. Software loads the constant and counter values while a channel is halted, then sets the channel's run bit. The underflow is acknowledged by writing the channel's control word with the flag bit at 0. Accesses use a simple synchronous port that answers one cycle after a read or write strobe.

Top module: `dctmr_top`

## Requirements
- R1: After reset, every run bit, every control word and every flag is 0, every counter and constant register reads 0xFFFFFFFF, and all interrupt outputs are low.
- R2: The run-control register is at byte address 0x04. Bit n set lets channel n count, and bit n clear halts it. A channel responds only to its own bit.
- R3: Channel n's registers start at byte address 0x08 + 12·n: the constant at +0, the counter at +4 and the control word at +8. In the control word, bits [2:0] are the clock select, bit 5 is the interrupt enable and bit 8 is the underflow flag. All other control bits read 0.
- R4: A clock select of 0, 1, 2, 3 or 4 divides the peripheral clock by 4, 16, 64, 256 or 1024. The values 5 to 7 also divide by 1024.
- R5: The prescaler restarts when a channel is started, so the first decrement comes exactly one divisor after the clock edge that sets the run bit. With a constant D and a counter loaded with D, the flag rises exactly (D+1)·divisor cycles after that edge, and the counter then holds D again.
- R6: Writes to the counter and constant registers are ignored while the channel runs and take effect while it is halted. The counter can be read at any time.
- R7: The flag is cleared only by a control write with bit 8 at 0. A control write with bit 8 at 1 leaves the flag set.
- R8: A channel's interrupt output is high exactly when both its flag and its enable bit are 1, and it stays high until one of them is cleared.
- R9: When an underflow and a flag-clearing control write fall on the same edge, the flag ends up set.
- R10: The ready output is high for exactly the one cycle after a read or write strobe, and read data is valid while ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access acknowledge, one cycle after the strobe |
| irq | output | N_CH | Per-channel underflow interrupt |

## Verification
The two actions that can meet on one edge are the hardware setting the flag at underflow and software clearing it with a control write. The bench provokes this with a constant of 0 at divide-by-4, which makes a channel underflow every fourth cycle. It counts cycles from the start edge so that the acknowledging write is captured on exactly the eighth cycle, which is an underflow edge. The interrupt output must still be high just after that edge. A later clearing write, placed on a cycle with no underflow, must drop the interrupt.

// File: rtl/dctmr_pkg.sv
package dctmr_pkg;

    localparam int CNT_W    = 32;
    localparam int PS_W     = 10;
    localparam int SEL_W    = 3;
    localparam int IE_BIT   = 5;
    localparam int FLAG_BIT = 8;

    localparam logic [15:0] START_OFS  = 16'h0004;
    localparam logic [15:0] GRP_BASE   = 16'h0008;
    localparam logic [15:0] GRP_STRIDE = 16'd12;

    typedef enum logic [1:0] {
        FLD_RELOAD = 2'd0,
        FLD_COUNT  = 2'd1,
        FLD_CTRL   = 2'd2
    } fld_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             ie;
        logic             flag;
    } ctrl_t;

    typedef struct packed {
        logic       hit_start;
        logic       hit_chan;
        logic [1:0] chan;
        fld_e       fld;
    } dec_t;

    // terminal value of the prescaler count for a clock select
    function automatic logic [PS_W-1:0] ps_limit(input logic [SEL_W-1:0] sel);
        logic [PS_W-1:0] lim;
        case (sel)
            3'd0:    lim = 10'd3;
            3'd1:    lim = 10'd15;
            3'd2:    lim = 10'd63;
            3'd3:    lim = 10'd255;
            default: lim = 10'd1023;
        endcase
        return lim;
    endfunction

    function automatic logic [CNT_W-1:0] pack_ctrl(input ctrl_t c);
        logic [CNT_W-1:0] w;
        w              = '0;
        w[SEL_W-1:0]   = c.sel;
        w[IE_BIT]      = c.ie;
        w[FLAG_BIT]    = c.flag;
        return w;
    endfunction

    function automatic dec_t decode_addr(input logic [15:0] a);
        dec_t        d;
        logic [15:0] off;
        logic [15:0] q;
        logic [15:0] r;
        d     = '0;
        d.fld = FLD_RELOAD;
        off   = a - GRP_BASE;
        q     = off / GRP_STRIDE;
        r     = off - 16'(q * GRP_STRIDE);
        if (a == START_OFS) begin
            d.hit_start = 1'b1;
        end else if (a >= GRP_BASE && q < 16'd4) begin
            d.chan = q[1:0];
            if (r == 16'd0) begin
                d.hit_chan = 1'b1;
                d.fld      = FLD_RELOAD;
            end else if (r == 16'd4) begin
                d.hit_chan = 1'b1;
                d.fld      = FLD_COUNT;
            end else if (r == 16'd8) begin
                d.hit_chan = 1'b1;
                d.fld      = FLD_CTRL;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/dctmr_prescale.sv
module dctmr_prescale
    import dctmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    logic [PS_W-1:0] pcnt_q;
    logic [PS_W-1:0] lim;

    always_comb begin
        lim    = ps_limit(sel_i);
        tick_o = run_i && (pcnt_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            pcnt_q <= '0;
        end else if (tick_o) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (pcnt_q == '0)); // R5

endmodule

// File: rtl/dctmr_chan.sv
module dctmr_chan
    import dctmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             rel_we_i,
    input  logic             cnt_we_i,
    input  logic             ctl_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rel_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] ctl_o,
    output logic             irq_o
);

    ctrl_t            ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rel_q;
    logic             tick;
    logic             uf;

    dctmr_prescale u_ps (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run_i),
        .sel_i  (ctl_q.sel),
        .tick_o (tick)
    );

    assign uf = tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
            rel_q <= '1;
            ctl_q <= '0;
        end else begin
            if (rel_we_i && !run_i) begin
                rel_q <= wdata_i;
            end
            if (cnt_we_i && !run_i) begin
                cnt_q <= wdata_i;
            end else if (tick) begin
                cnt_q <= uf ? rel_q : cnt_q - 1'b1;
            end
            if (ctl_we_i) begin
                ctl_q.sel <= wdata_i[SEL_W-1:0];
                ctl_q.ie  <= wdata_i[IE_BIT];
            end
            // hardware set has priority over a software clear
            if (uf) begin
                ctl_q.flag <= 1'b1;
            end else if (ctl_we_i && !wdata_i[FLAG_BIT]) begin
                ctl_q.flag <= 1'b0;
            end
        end
    end

    assign rel_o = rel_q;
    assign cnt_o = cnt_q;
    assign ctl_o = pack_ctrl(ctl_q);
    assign irq_o = ctl_q.flag & ctl_q.ie;

    AST_RELOAD_ON_UF: assert property (@(posedge clk) disable iff (rst)
        uf |=> (cnt_q == $past(rel_q))); // R5

    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !(cnt_we_i && !run_i)) |=> $stable(cnt_q)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.flag && !(ctl_we_i && !wdata_i[FLAG_BIT])) |=> ctl_q.flag); // R7

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !ctl_we_i) |=> irq_o); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (uf && ctl_we_i) |=> ctl_q.flag); // R9

endmodule

// File: rtl/dctmr_busif.sv
module dctmr_busif
    import dctmr_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_i,
    input  logic                       wr_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [N_CH-1:0]            start_data_i,
    input  logic [N_CH-1:0][CNT_W-1:0] rel_i,
    input  logic [N_CH-1:0][CNT_W-1:0] cnt_i,
    input  logic [N_CH-1:0][CNT_W-1:0] ctl_i,
    output logic [N_CH-1:0]            run_o,
    output logic [N_CH-1:0]            rel_we_o,
    output logic [N_CH-1:0]            cnt_we_o,
    output logic [N_CH-1:0]            ctl_we_o,
    output logic [CNT_W-1:0]           rdata_o,
    output logic                       ready_o
);

    dec_t             dec;
    logic             ch_ok;
    logic [CNT_W-1:0] rd_mux;
    logic [N_CH-1:0]  run_q;

    always_comb begin
        dec   = decode_addr(16'(addr_i));
        ch_ok = dec.hit_chan && (int'(dec.chan) < N_CH);
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_we
        logic sel_c;
        assign sel_c       = wr_i && ch_ok && (dec.chan == 2'(c));
        assign rel_we_o[c] = sel_c && (dec.fld == FLD_RELOAD);
        assign cnt_we_o[c] = sel_c && (dec.fld == FLD_COUNT);
        assign ctl_we_o[c] = sel_c && (dec.fld == FLD_CTRL);
    end

    always_comb begin
        rd_mux = '0;
        if (dec.hit_start) begin
            rd_mux = CNT_W'(run_q);
        end
        for (int c = 0; c < N_CH; c++) begin
            if (ch_ok && dec.chan == 2'(c)) begin
                case (dec.fld)
                    FLD_RELOAD: rd_mux = rel_i[c];
                    FLD_COUNT:  rd_mux = cnt_i[c];
                    default:    rd_mux = ctl_i[c];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            rdata_o <= '0;
            ready_o <= 1'b0;
        end else begin
            ready_o <= rd_i || wr_i;
            if (rd_i) begin
                rdata_o <= rd_mux;
            end
            if (wr_i && dec.hit_start) begin
                run_q <= start_data_i;
            end
        end
    end

    assign run_o = run_q;

    AST_RUN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && dec.hit_start) |=> $stable(run_o)); // R2

endmodule

// File: rtl/dctmr_top.sv
module dctmr_top
    import dctmr_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_ready,
    output logic [N_CH-1:0]   irq
);

    logic [N_CH-1:0]            run;
    logic [N_CH-1:0]            rel_we;
    logic [N_CH-1:0]            cnt_we;
    logic [N_CH-1:0]            ctl_we;
    logic [N_CH-1:0][CNT_W-1:0] rel_v;
    logic [N_CH-1:0][CNT_W-1:0] cnt_v;
    logic [N_CH-1:0][CNT_W-1:0] ctl_v;

    dctmr_busif #(
        .N_CH   (N_CH),
        .ADDR_W (ADDR_W)
    ) u_bus (
        .clk          (clk),
        .rst          (rst),
        .rd_i         (bus_rd),
        .wr_i         (bus_wr),
        .addr_i       (bus_addr),
        .start_data_i (bus_wdata[N_CH-1:0]),
        .rel_i        (rel_v),
        .cnt_i        (cnt_v),
        .ctl_i        (ctl_v),
        .run_o        (run),
        .rel_we_o     (rel_we),
        .cnt_we_o     (cnt_we),
        .ctl_we_o     (ctl_we),
        .rdata_o      (bus_rdata),
        .ready_o      (bus_ready)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        dctmr_chan u_ch (
            .clk      (clk),
            .rst      (rst),
            .run_i    (run[c]),
            .rel_we_i (rel_we[c]),
            .cnt_we_i (cnt_we[c]),
            .ctl_we_i (ctl_we[c]),
            .wdata_i  (bus_wdata),
            .rel_o    (rel_v[c]),
            .cnt_o    (cnt_v[c]),
            .ctl_o    (ctl_v[c]),
            .irq_o    (irq[c])
        );
    end

endmodule

// File: tb/dctmr_tb.sv
`timescale 1ns/1ps
module dctmr_top_tb_top;

    localparam int N_CH = 3;
    localparam logic [7:0] A_START = 8'h04;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_ready;
    logic [N_CH-1:0]   irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dctmr_top #(.N_CH(N_CH), .ADDR_W(8)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .irq       (irq)
    );

    function automatic logic [7:0] a_rel(input int ch); return 8'(8 + 12*ch);  endfunction
    function automatic logic [7:0] a_cnt(input int ch); return 8'(12 + 12*ch); endfunction
    function automatic logic [7:0] a_ctl(input int ch); return 8'(16 + 12*ch); endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // strobe set on a falling edge, captured by the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 write ready", 32'(bus_ready), 32'd1);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R10 read ready", 32'(bus_ready), 32'd1);
        d = bus_rdata;
        @(negedge clk);
        chk("R10 ready drop", 32'(bus_ready), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", 32'(irq), 32'd0);
        rd(A_START, v);  chk("R1 start", v, 32'h0);
        for (int c = 0; c < N_CH; c++) begin
            rd(a_ctl(c), v); chk("R1 ctrl", v, 32'h0);
            rd(a_cnt(c), v); chk("R1 count", v, 32'hFFFF_FFFF);
            rd(a_rel(c), v); chk("R1 reload", v, 32'hFFFF_FFFF);
        end
    endtask

    // channel 0, divide by 4, reload 3: flag after 16 cycles
    task automatic t_period();
        logic [31:0] v;
        wr(a_rel(0), 32'd3);
        wr(a_cnt(0), 32'd3);
        wr(a_ctl(0), 32'h20);
        wr(A_START, 32'h1);
        repeat (15) @(posedge clk);
        #1 chk("R5 no flag before period", 32'(irq[0]), 32'd0);
        @(posedge clk);
        #1 chk("R5 R8 flag at period", 32'(irq[0]), 32'd1);
        wr(A_START, 32'h0);
        rd(a_cnt(0), v);  chk("R5 reloaded count", v, 32'd3);
        rd(a_ctl(0), v);  chk("R3 ctrl layout", v, 32'h120);
        rd(A_START, v);   chk("R2 start readback", v, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        wr(a_ctl(0), 32'h120);
        chk("R7 write one keeps flag", 32'(irq[0]), 32'd1);
        wr(a_ctl(0), 32'h100);
        chk("R8 enable off masks", 32'(irq[0]), 32'd0);
        rd(a_ctl(0), v);  chk("R7 flag still set", v, 32'h100);
        wr(a_ctl(0), 32'h020);
        rd(a_ctl(0), v);  chk("R7 flag cleared", v, 32'h020);
        chk("R8 irq low after clear", 32'(irq[0]), 32'd0);
        wr(a_ctl(0), 32'h0);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        // channel 1 at divide by 16, reload 1: 32 cycles
        wr(a_rel(1), 32'd1);
        wr(a_cnt(1), 32'd1);
        wr(a_ctl(1), 32'h21);
        wr(A_START, 32'h2);
        repeat (31) @(posedge clk);
        #1 chk("R4 div16 early", 32'(irq[1]), 32'd0);
        @(posedge clk);
        #1 chk("R4 div16 on time", 32'(irq[1]), 32'd1);
        chk("R2 channel 0 untouched", 32'(irq[0]), 32'd0);
        wr(A_START, 32'h0);
        wr(a_ctl(1), 32'h0);
        // channel 2 with select 5 acts as divide by 1024, reload 0
        wr(a_rel(2), 32'd0);
        wr(a_cnt(2), 32'd0);
        wr(a_ctl(2), 32'h25);
        wr(A_START, 32'h4);
        repeat (1023) @(posedge clk);
        #1 chk("R4 div1024 early", 32'(irq[2]), 32'd0);
        @(posedge clk);
        #1 chk("R4 div1024 on time", 32'(irq[2]), 32'd1);
        wr(A_START, 32'h0);
        wr(a_ctl(2), 32'h0);
        rd(a_ctl(2), v);  chk("R4 ctrl cleared", v, 32'h0);
    endtask

    task automatic t_ignore_run();
        logic [31:0] v;
        wr(a_rel(0), 32'd100);
        wr(a_cnt(0), 32'd100);
        wr(a_ctl(0), 32'h4);
        wr(A_START, 32'h1);
        wr(a_cnt(0), 32'd5);
        wr(a_rel(0), 32'd7);
        rd(a_cnt(0), v);  chk("R6 count write ignored while running", v, 32'd100);
        rd(a_rel(0), v);  chk("R6 reload write ignored while running", v, 32'd100);
        wr(A_START, 32'h0);
        wr(a_cnt(0), 32'd9);
        rd(a_cnt(0), v);  chk("R6 count write while halted", v, 32'd9);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(a_rel(0), 32'd0);
        wr(a_cnt(0), 32'd0);
        wr(a_ctl(0), 32'h20);
        wr(A_START, 32'h1);
        // underflows every 4 cycles; place the clear on the 8th edge
        repeat (6) @(negedge clk);
        wr(a_ctl(0), 32'h20);
        chk("R9 set wins over clear", 32'(irq[0]), 32'd1);
        wr(A_START, 32'h0);
        wr(a_ctl(0), 32'h20);
        chk("R7 clear without underflow", 32'(irq[0]), 32'd0);
        rd(a_ctl(0), v);  chk("R7 flag readback", v, 32'h20);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_period();
        t_sticky();
        t_prescale();
        t_ignore_run();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule